// File: doc/BRIEF.md
# System Clock Ratio Detector with Power-Up Reset

This block runs on the converter's system clock. It holds the rest of the design in an internal reset for a fixed number of system clocks after power-good is asserted. Once that reset is released, it measures the audio word clock. It counts the system clocks between successive rising edges of the word clock and classifies the count as one of six supported clock-to-sample-rate ratios.

The classified ratio drives the per-channel force-zero outputs. At the two lowest ratios, the word clock runs too fast for four of the six channels. Those four are held at the bipolar zero code, and the first stereo pair keeps running. If a measured period matches no supported ratio, the valid flag drops and every channel is forced to zero until a stable ratio is seen again.

Power-good enters as the active-low asynchronous reset. The word clock may be asynchronous to the system clock and is synchronised inside the block.

Top module: `clk_ratio_detect`

## Requirements
- R1: While rst_ni is low, int_rst_o is 1. After rst_ni rises, int_rst_o stays 1 through the first 1023 rising clock edges and is 0 from the 1024th edge on.
- R2: While int_rst_o is 1, the detector is idle and word-clock edges are ignored. ratio_vld_o is 0 and force_zero_o is all ones.
- R3: A period is the number of system clock edges between two successive synchronised rising edges of lrck_i. It is accepted when it lies within ±2 of 128, 192, 256, 384, 512 or 768. Those ratios carry ratio_code_o values 0, 1, 2, 3, 4 and 5.
- R4: ratio_code_o takes a new value, and ratio_vld_o rises, only after two consecutive accepted periods have matched the same ratio. The first rising edge after the internal reset starts the measurement but yields no period.
- R5: A single accepted period that differs from the confirmed ratio leaves ratio_code_o and ratio_vld_o unchanged.
- R6: A period outside every window clears ratio_vld_o. This includes a period that saturates the counter at 1023. While ratio_vld_o is 0, force_zero_o is all ones.
- R7: With ratio_vld_o = 1 and ratio_code_o of 0 or 1, force_zero_o is 6'b111100. Bits 0 and 1, the first stereo pair, stay 0.
- R8: With ratio_vld_o = 1 and ratio_code_o of 2 to 5, force_zero_o is 0.
- R9: Outputs reflect a word-clock rise on the third rising clock edge after the edge that first samples lrck_i high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous power-good, low = power not good |
| lrck_i | input | 1 | Word clock, asynchronous, one period per sample |
| int_rst_o | output | 1 | Internal reset for the rest of the design, active high |
| ratio_code_o | output | 3 | Confirmed ratio code (0..5 = 128,192,256,384,512,768) |
| ratio_vld_o | output | 1 | Confirmed ratio is valid |
| force_zero_o | output | 6 | Per-channel force to bipolar zero, bit n = channel n+1 |

## Verification
The assertions assume that lrck_i is stable around each sampling edge long enough for the two-flop synchroniser to resolve. They also assume that power-good only toggles as a level, with no glitches shorter than a clock. The bench meets both conditions by changing lrck_i and rst_ni just after a rising clock edge and holding each level for whole clock cycles. Every word-clock period is an exact integer number of system clocks, so each measured count is known in advance. The stimulus covers:
- each ratio window, including its ±2 edges;
- periods just outside a window;
- periods long enough to saturate the counter.

// File: rtl/crd_pkg.sv
package crd_pkg;
  localparam int unsigned NRATIO = 6;
  localparam int unsigned CODE_W = 3;
  localparam int unsigned LOW_RATIOS = 2;  // codes below this mute the upper channels
  typedef logic [CODE_W-1:0] code_t;

  function automatic int unsigned nominal_ratio(input int unsigned idx);
    case (idx)
      0: return 128;
      1: return 192;
      2: return 256;
      3: return 384;
      4: return 512;
      default: return 768;
    endcase
  endfunction
endpackage

// File: rtl/por_timer.sv
module por_timer #(
  parameter int unsigned INIT_CYC = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(INIT_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CW'(INIT_CYC - 1)) busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;

  // R1: once released, internal reset stays released until power-good drops
  a_r1_release_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> !busy_o);
endmodule

// File: rtl/lrck_edge.sv
module lrck_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lrck_i,
  output logic rise_o
);
  logic [SYNC_STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_STAGES-1:0], lrck_i};
  end

  assign rise_o = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
endmodule

// File: rtl/period_meter.sv
module period_meter #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             idle_i,
  input  logic             rise_i,
  output logic [CNT_W-1:0] meas_o,
  output logic             meas_vld_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, meas_q;
  logic             armed_q, vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      meas_q  <= '0;
      armed_q <= 1'b0;
      vld_q   <= 1'b0;
    end else if (idle_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      vld_q   <= 1'b0;
    end else if (rise_i) begin
      meas_q  <= cnt_q;
      vld_q   <= armed_q;
      cnt_q   <= CNT_W'(1);
      armed_q <= 1'b1;
    end else begin
      vld_q <= 1'b0;
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign meas_o     = meas_q;
  assign meas_vld_o = vld_q;

  // R3: a measurement is only produced on a detected word-clock rise
  a_r3_meas_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_vld_o |-> $past(rise_i));
  // R2: nothing is measured while held idle
  a_r2_idle_no_meas: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i |=> !meas_vld_o);
endmodule

// File: rtl/ratio_classifier.sv
module ratio_classifier
  import crd_pkg::*;
#(
  parameter int unsigned CNT_W = 10,
  parameter int unsigned TOL   = 2,
  parameter int unsigned NCH   = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             idle_i,
  input  logic [CNT_W-1:0] meas_i,
  input  logic             meas_vld_i,
  output code_t            code_o,
  output logic             vld_o,
  output logic [NCH-1:0]   mute_o
);
  localparam int unsigned KEEP_CH = 2;

  logic [NRATIO-1:0] hit;
  code_t             hit_idx;
  logic              any_hit;
  code_t             code_q, cand_q;
  logic              vld_q, cand_vld_q;

  for (genvar g = 0; g < NRATIO; g++) begin : g_win
    localparam int unsigned LO = nominal_ratio(g) - TOL;
    localparam int unsigned HI = nominal_ratio(g) + TOL;
    assign hit[g] = (meas_i >= CNT_W'(LO)) && (meas_i <= CNT_W'(HI));
  end

  always_comb begin
    hit_idx = '0;
    any_hit = 1'b0;
    for (int i = NRATIO - 1; i >= 0; i--) begin
      if (hit[i]) begin
        hit_idx = CODE_W'(i);
        any_hit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q     <= '0;
      cand_q     <= '0;
      vld_q      <= 1'b0;
      cand_vld_q <= 1'b0;
    end else if (idle_i) begin
      code_q     <= '0;
      vld_q      <= 1'b0;
      cand_vld_q <= 1'b0;
    end else if (meas_vld_i) begin
      if (any_hit) begin
        if (cand_vld_q && cand_q == hit_idx) begin
          code_q <= hit_idx;
          vld_q  <= 1'b1;
        end
        cand_q     <= hit_idx;
        cand_vld_q <= 1'b1;
      end else begin
        vld_q      <= 1'b0;
        cand_vld_q <= 1'b0;
      end
    end
  end

  always_comb begin
    mute_o = '0;
    if (!vld_q) mute_o = '1;
    else if (code_q < CODE_W'(LOW_RATIOS)) mute_o[NCH-1:KEEP_CH] = '1;
  end

  assign code_o = code_q;
  assign vld_o  = vld_q;

  // R2: idle forces invalid on the next edge
  a_r2_idle_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i |=> !vld_o);
  // R4: code only moves in the cycle after a measurement
  a_r4_code_on_meas: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o != $past(code_o)) |-> ($past(meas_vld_i) || $past(idle_i)));
  // R4: validity rises only with a pending candidate confirmed
  a_r4_vld_confirmed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vld_o) |-> $past(cand_vld_q) && $past(meas_vld_i));
endmodule

// File: rtl/clk_ratio_detect.sv
module clk_ratio_detect
  import crd_pkg::*;
#(
  parameter int unsigned INIT_CYC    = 1024,
  parameter int unsigned CNT_W       = 10,
  parameter int unsigned TOL         = 2,
  parameter int unsigned NCH         = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                lrck_i,
  output logic                int_rst_o,
  output logic [CODE_W-1:0]   ratio_code_o,
  output logic                ratio_vld_o,
  output logic [NCH-1:0]      force_zero_o
);
  logic             busy, rise, meas_vld;
  logic [CNT_W-1:0] meas;

  por_timer #(.INIT_CYC(INIT_CYC)) u_por (
    .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy)
  );

  lrck_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .lrck_i(lrck_i), .rise_o(rise)
  );

  period_meter #(.CNT_W(CNT_W)) u_meter (
    .clk_i(clk_i), .rst_ni(rst_ni), .idle_i(busy), .rise_i(rise),
    .meas_o(meas), .meas_vld_o(meas_vld)
  );

  ratio_classifier #(.CNT_W(CNT_W), .TOL(TOL), .NCH(NCH)) u_cls (
    .clk_i(clk_i), .rst_ni(rst_ni), .idle_i(busy), .meas_i(meas),
    .meas_vld_i(meas_vld), .code_o(ratio_code_o), .vld_o(ratio_vld_o),
    .mute_o(force_zero_o)
  );

  assign int_rst_o = busy;

  // R6: an invalid ratio mutes every channel
  a_r6_invalid_all_mute: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ratio_vld_o |-> &force_zero_o);
  // R7: low ratios keep the first pair and mute the rest
  a_r7_low_ratio_mute: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio_vld_o && ratio_code_o < CODE_W'(LOW_RATIOS)) |->
      (force_zero_o[1:0] == 2'b00) && (&force_zero_o[NCH-1:2]));
  // R8: higher ratios mute nothing
  a_r8_high_ratio_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio_vld_o && ratio_code_o >= CODE_W'(LOW_RATIOS)) |-> (force_zero_o == '0));
endmodule

// File: tb/tb_clk_ratio_detect.sv
module tb_clk_ratio_detect;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       lrck_i = 1'b0;
  logic       int_rst_o;
  logic [2:0] ratio_code_o;
  logic       ratio_vld_o;
  logic [5:0] force_zero_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  clk_ratio_detect dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .lrck_i(lrck_i), .int_rst_o(int_rst_o),
    .ratio_code_o(ratio_code_o), .ratio_vld_o(ratio_vld_o),
    .force_zero_o(force_zero_o)
  );

  // ---- behavioural reference ----
  int ratios[6] = '{128, 192, 256, 384, 512, 768};
  int m_edges, m_cnt, m_meas, m_cand, m_code;
  bit m_armed, m_mv, m_cand_v, m_vld;
  bit lr_hist[$];

  function automatic int classify(input int p);
    for (int i = 0; i < 6; i++)
      if (p >= ratios[i] - 2 && p <= ratios[i] + 2) return i;
    return -1;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_edges = 0; m_cnt = 0; m_meas = 0; m_cand = 0; m_code = 0;
      m_armed = 0; m_mv = 0; m_cand_v = 0; m_vld = 0;
      lr_hist = '{0, 0, 0};
    end else begin
      bit idle;
      bit rise;
      int idx;
      idle = (m_edges < 1024);
      rise = lr_hist[1] && !lr_hist[2];
      if (idle) begin
        m_vld = 0; m_cand_v = 0; m_code = 0;
      end else if (m_mv) begin
        idx = classify(m_meas);
        if (idx >= 0) begin
          if (m_cand_v && m_cand == idx) begin m_code = idx; m_vld = 1; end
          m_cand = idx; m_cand_v = 1;
        end else begin
          m_vld = 0; m_cand_v = 0;
        end
      end
      if (idle) begin
        m_cnt = 0; m_armed = 0; m_mv = 0;
      end else if (rise) begin
        m_mv = m_armed; m_meas = m_cnt; m_cnt = 1; m_armed = 1;
      end else begin
        m_mv = 0;
        if (m_cnt < 1023) m_cnt++;
      end
      lr_hist.push_front(lrck_i);
      void'(lr_hist.pop_back());
      if (m_edges < 1024) m_edges++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk_i) begin
    if (!done) begin
      int exp_fz;
      exp_fz = !m_vld ? 6'h3F : (m_code < 2 ? 6'h3C : 6'h00);
      check("R1 int_rst", int'(int_rst_o), (!rst_ni || m_edges < 1024) ? 1 : 0);
      check("R4 ratio_vld", int'(ratio_vld_o), int'(m_vld));
      check("R3 ratio_code", int'(ratio_code_o), m_code);
      check("R6 force_zero", int'(force_zero_o), exp_fz);
    end
  end

  task automatic finish_run;
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  task automatic lr_periods(input int per, input int n);
    for (int k = 0; k < n; k++) begin
      lrck_i = 1'b1;
      repeat (per / 2) @(posedge clk_i);
      #2;
      lrck_i = 1'b0;
      repeat (per - per / 2) @(posedge clk_i);
      #2;
    end
  endtask

  task automatic expect_out(input string req, input int vld, input int code, input int fz);
    @(negedge clk_i);
    check({req, " vld"}, int'(ratio_vld_o), vld);
    if (vld) check({req, " code"}, int'(ratio_code_o), code);
    check({req, " force_zero"}, int'(force_zero_o), fz);
    @(posedge clk_i); #2;
  endtask

  task automatic por_sequence;
    @(negedge clk_i);
    check("R2 vld in reset", int'(ratio_vld_o), 0);
    check("R2 force_zero in reset", int'(force_zero_o), 6'h3F);
    @(posedge clk_i); #2;
    rst_ni = 1'b1;
    repeat (1023) @(posedge clk_i);
    @(negedge clk_i);
    check("R1 held at edge 1023", int'(int_rst_o), 1);
    @(posedge clk_i);
    @(negedge clk_i);
    check("R1 released at edge 1024", int'(int_rst_o), 0);
    @(posedge clk_i); #2;
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #2;
    por_sequence();

    lr_periods(256, 4);
    expect_out("R8 ratio 256", 1, 2, 6'h00);
    lr_periods(128, 4);
    expect_out("R7 ratio 128", 1, 0, 6'h3C);
    lr_periods(194, 4);
    expect_out("R3 ratio 192+2", 1, 1, 6'h3C);
    lr_periods(766, 3);
    expect_out("R8 ratio 768-2", 1, 5, 6'h00);
    lr_periods(512, 1);
    lr_periods(766, 1);
    expect_out("R5 single 512 ignored", 1, 5, 6'h00);
    lr_periods(766, 1);
    lr_periods(300, 3);
    expect_out("R6 count 300", 0, 0, 6'h3F);
    lr_periods(384, 4);
    expect_out("R4 ratio 384 reconfirmed", 1, 3, 6'h00);
    lr_periods(1100, 2);
    expect_out("R6 saturated count", 0, 0, 6'h3F);
    lr_periods(256, 4);
    expect_out("R4 ratio 256 again", 1, 2, 6'h00);
    lr_periods(131, 3);
    expect_out("R3 count 131 outside", 0, 0, 6'h3F);
    lr_periods(510, 4);
    expect_out("R3 ratio 512-2", 1, 4, 6'h00);

    // power-good drop mid run, then word clock during init is ignored
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1 int_rst on power-good drop", int'(int_rst_o), 1);
    check("R2 vld on power-good drop", int'(ratio_vld_o), 0);
    @(posedge clk_i); #2;
    rst_ni = 1'b1;
    lr_periods(256, 3);
    expect_out("R2 idle during init", 0, 0, 6'h3F);
    repeat (300) @(posedge clk_i);
    #2;
    lr_periods(192, 3);
    expect_out("R9 R7 ratio 192 after init", 1, 1, 6'h3C);
    finish_run();
  end
endmodule